// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block is the mode-control state machine of a CAN protocol controller. It holds the current operating mode (Configuration, Normal, Sleep, Snoop or Loopback) and decides, cycle by cycle, when a mode may be entered or left. Its inputs are the software control bits, the transmit queue status, the receive line and a sample-point strobe. From the receive line and the strobe it derives its own bus-idle indication.

Software leaves Configuration by setting the enable bit. The select bits then pick the mode. Sleep is entered only when both transmit queues have drained, and, when coming from Normal, only after the bus has gone idle. Sleep is left on receive-line activity or on a software write into either transmit queue. On that exit the hardware clears the sleep request bit and can raise a one-cycle wake interrupt.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset `mode` is Configuration (code 0), `cfg_flag` is 1, and `sleep_req` and `wake_irq` are 0.
- R2: When `en` is 0 at a clock edge, `mode` is Configuration after that edge, whatever the previous mode was. `cfg_flag` is 1 exactly while `mode` is Configuration.
- R3: In Configuration, with `en` at 1, the next mode is chosen with this priority: Loopback (code 4) if `lback_sel` is 1, else Snoop (code 3) if `snoop_sel` is 1, else Sleep or Normal (code 1) as set out in R4.
- R4: Leaving Configuration with neither select bit set, the block goes straight to Sleep (code 2) if `sleep_req` is 1 and both transmit queues are empty. It does not wait for bus idle. Otherwise it goes to Normal.
- R5: Normal moves to Sleep only when `sleep_req` is 1, both queues are empty and the bus is idle. The bus is idle once IDLE_BITS (11) consecutive `sample_pt` strobes have seen `rx` at 1. A strobe that sees `rx` at 0 restarts the count.
- R6: While `en` stays 1, changes to `lback_sel` and `snoop_sel` do not move the block out of Normal, Loopback or Snoop.
- R7: In Sleep with `en` at 1, any of these moves the block to Normal at the next edge and clears `sleep_req`: `rx` at 0 in any cycle, a `txf_wr` pulse, or a `txh_wr` pulse. The hardware clear wins over a simultaneous software write.
- R8: `wake_irq` is a single-cycle pulse. It is high in the first cycle of Normal after an R7 exit, and only if `wake_ie` was 1 at that exit.
- R9: A `sleep_wr` pulse loads `sleep_wdata` into `sleep_req`, unless an R7 exit occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Core enable bit |
| lback_sel | input | 1 | Loopback select bit |
| snoop_sel | input | 1 | Snoop select bit |
| sleep_wr | input | 1 | Software write strobe for the sleep request bit |
| sleep_wdata | input | 1 | Value written to the sleep request bit |
| rx | input | 1 | Receive line, 1 = recessive |
| sample_pt | input | 1 | Bit sample-point strobe |
| txf_empty | input | 1 | Transmit FIFO empty |
| txh_empty | input | 1 | High-priority transmit buffer empty |
| txf_wr | input | 1 | Software write into transmit FIFO |
| txh_wr | input | 1 | Software write into high-priority buffer |
| wake_ie | input | 1 | Wake interrupt enable |
| mode | output | 3 | Current mode: 0 Config, 1 Normal, 2 Sleep, 3 Snoop, 4 Loopback |
| cfg_flag | output | 1 | 1 while in Configuration |
| sleep_req | output | 1 | Sleep request bit, cleared by hardware on wake |
| wake_irq | output | 1 | Wake interrupt pulse |

## Verification
The hardest state to reach is the entry from Normal into Sleep. It needs a set sleep request, two empty queues and an unbroken run of eleven recessive sample strobes, all at the same time. Under random stimulus that combination rarely appears. Directed sequences therefore supply exactly ten strobes and then the eleventh, and they also break a run with a single dominant sample. The random phase holds the queue flags mostly empty and the receive line mostly recessive, so that the Sleep state and its wake exits occur often.

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl #(
  parameter int IDLE_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       lback_sel,
  input  logic       snoop_sel,
  input  logic       sleep_wr,
  input  logic       sleep_wdata,
  input  logic       rx,
  input  logic       sample_pt,
  input  logic       txf_empty,
  input  logic       txh_empty,
  input  logic       txf_wr,
  input  logic       txh_wr,
  input  logic       wake_ie,
  output logic [2:0] mode,
  output logic       cfg_flag,
  output logic       sleep_req,
  output logic       wake_irq
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_BITS);
  localparam logic [2:0] M_CFG = 3'd0, M_NORM = 3'd1, M_SLEEP = 3'd2,
                         M_SNOOP = 3'd3, M_LOOP = 3'd4;

  logic [CW-1:0] idle_cnt;
  logic [2:0]    mode_nx;
  logic          bus_idle, drained, wake;

  assign bus_idle = idle_cnt == IDLE_MAX;
  assign drained  = txf_empty & txh_empty;
  assign wake     = en & (mode == M_SLEEP) & (~rx | txf_wr | txh_wr);
  assign cfg_flag = mode == M_CFG;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 idle_cnt <= '0;
    else if (sample_pt && !rx)  idle_cnt <= '0;
    else if (sample_pt && !bus_idle) idle_cnt <= idle_cnt + 1'b1;

  always_comb begin
    mode_nx = mode;
    if (!en) mode_nx = M_CFG;
    else case (mode)
      M_CFG:   if (lback_sel)                mode_nx = M_LOOP;
               else if (snoop_sel)           mode_nx = M_SNOOP;
               else if (sleep_req && drained) mode_nx = M_SLEEP;
               else                          mode_nx = M_NORM;
      M_NORM:  if (sleep_req && drained && bus_idle) mode_nx = M_SLEEP;
      M_SLEEP: if (wake) mode_nx = M_NORM;
      default: mode_nx = mode;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode      <= M_CFG;
      sleep_req <= 1'b0;
      wake_irq  <= 1'b0;
    end else begin
      mode     <= mode_nx;
      wake_irq <= wake & wake_ie;
      if (wake)          sleep_req <= 1'b0;
      else if (sleep_wr) sleep_req <= sleep_wdata;
    end

  p_disable_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> mode == M_CFG);
  p_hold_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (mode == M_LOOP || mode == M_SNOOP)) ##1 en |-> $stable(mode));
  p_sleep_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_SLEEP) ##1 (mode == M_SLEEP) |-> $past(sleep_req && drained));
  p_sleep_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM) ##1 (mode == M_SLEEP) |-> $past(bus_idle));
  p_wake_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && en && !rx) |=> (mode == M_NORM && !sleep_req));
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> !wake_irq);
  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> $past(mode == M_SLEEP && wake_ie) && mode == M_NORM);
endmodule

// File: tb/can_mode_ctrl_test.sv
module can_mode_ctrl_test;
  localparam int CLK_P = 10;
  localparam int IDLE = 11;
  localparam logic [2:0] CFG = 0, NORM = 1, SLP = 2, SNP = 3, LBK = 4;

  logic clk = 0, rst_n = 0;
  logic en = 0, lb = 0, sn = 0, swr = 0, swd = 0, rx = 1, sp = 0;
  logic fe = 1, he = 1, fwr = 0, hwr = 0, ie = 0;
  logic [2:0] mode;
  logic cfg_flag, sreq, irq;

  logic [2:0] m_mode = CFG;
  logic m_sreq = 0, m_irq = 0;
  int m_cnt = 0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  can_mode_ctrl #(.IDLE_BITS(IDLE)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .lback_sel(lb), .snoop_sel(sn),
    .sleep_wr(swr), .sleep_wdata(swd), .rx(rx), .sample_pt(sp),
    .txf_empty(fe), .txh_empty(he), .txf_wr(fwr), .txh_wr(hwr),
    .wake_ie(ie), .mode(mode), .cfg_flag(cfg_flag), .sleep_req(sreq),
    .wake_irq(irq));

  function automatic logic [2:0] next_mode();
    logic wk = m_mode == SLP && (!rx || fwr || hwr);
    if (!en) return CFG;
    case (m_mode)
      CFG:  return lb ? LBK : sn ? SNP : (m_sreq && fe && he) ? SLP : NORM;
      NORM: return (m_sreq && fe && he && m_cnt >= IDLE) ? SLP : NORM;
      SLP:  return wk ? NORM : SLP;
      default: return m_mode;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic wk = en && m_mode == SLP && (!rx || fwr || hwr);
    logic [2:0] nm = next_mode();
    @(negedge clk);
    m_irq = wk && ie;
    m_sreq = wk ? 1'b0 : (swr ? swd : m_sreq);
    if (sp) m_cnt = rx ? ((m_cnt >= IDLE) ? IDLE : m_cnt + 1) : 0;
    m_mode = nm;
    chk("R2 R3 R4 R5 R6 R7 mode", mode, m_mode);
    chk("R2 cfg_flag", cfg_flag, m_mode == CFG);
    chk("R7 R9 sleep_req", sreq, m_sreq);
    chk("R8 wake_irq", irq, m_irq);
    swr = 0; fwr = 0; hwr = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (2) @(negedge clk);
    rst_n = 1;
    chk("R1 mode", mode, CFG); chk("R1 cfg_flag", cfg_flag, 1);
    chk("R1 sleep_req", sreq, 0); chk("R1 wake_irq", irq, 0);
    // R3 priority, R6 hold, R2 disable
    lb = 1; sn = 1; en = 1; tick(); chk("R3 loop first", mode, LBK);
    lb = 0; tick(); tick(); chk("R6 loop held", mode, LBK);
    en = 0; tick(); chk("R2 back to config", mode, CFG);
    en = 1; tick(); chk("R3 snoop second", mode, SNP);
    en = 0; sn = 0; tick();
    // R9 then R4 direct sleep from config
    swr = 1; swd = 1; tick(); chk("R9 sleep bit set", sreq, 1);
    en = 1; tick(); chk("R4 config to sleep", mode, SLP);
    // R7 rx wake with simultaneous software write, R8 pulse
    ie = 1; rx = 0; swr = 1; swd = 1; tick();
    chk("R7 wake to normal", mode, NORM); chk("R7 hw clear wins", sreq, 0);
    chk("R8 irq high", irq, 1);
    rx = 1; tick(); chk("R8 irq one cycle", irq, 0);
    // R5 idle count: dominant sample restarts, 10 not enough, 11 enters
    swr = 1; swd = 1; tick();
    sp = 1; rx = 0; tick(); rx = 1;
    for (int i = 0; i < IDLE - 1; i++) tick();
    sp = 0; tick(); chk("R5 ten samples not idle", mode, NORM);
    sp = 1; tick(); sp = 0; tick(); chk("R5 eleventh sample sleeps", mode, SLP);
    // R7 transmit write wake, R8 gated off
    ie = 0; hwr = 1; tick();
    chk("R7 buffer write wakes", mode, NORM); chk("R8 irq gated", irq, 0);
    // R4 queues not empty -> normal
    en = 0; tick(); swr = 1; swd = 1; fe = 0; tick();
    en = 1; tick(); chk("R4 busy queue to normal", mode, NORM);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      en  = ($urandom % 40) != 0;
      lb  = ($urandom % 8) == 0;
      sn  = ($urandom % 6) == 0;
      swr = ($urandom % 10) == 0; swd = ($urandom % 4) != 0;
      rx  = ($urandom % 25) != 0;
      sp  = ($urandom % 2) == 0;
      fe  = ($urandom % 5) != 0;  he = ($urandom % 5) != 0;
      fwr = ($urandom % 30) == 0; hwr = ($urandom % 30) == 0;
      ie  = ($urandom % 2) == 0;
      tick();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule